// File: doc/BRIEF.md
# Widening Integer Add/Subtract Lane

This block handles one element lane of the vector widening integer add and subtract operations. Each cycle it can accept one 32-bit instruction word, a selected element width of 8, 16 or 32 bits, a wide first operand, a narrow vector element, a scalar register value and the per-element mask bit. It decodes the instruction, widens the operands as the operation demands, adds or subtracts at twice the element width, and one cycle later presents the double-width result with a write-enable and an illegal-instruction flag.

The operation field picks one of eight operations: unsigned or signed, add or subtract, each with a narrow or an already-wide first operand. The operand-source field picks where the narrow second operand comes from: a vector element or the low bits of the scalar register. Walking an element sequence across a register group, reading and writing the register file, and register-overlap checks are left to the surrounding pipeline.

Top module: `vwl_lane`

## Requirements
- R1: An instruction is accepted only when bits [6:0] equal 1010111, bits [14:12] equal 010 or 110, and bits [31:29] of the operation field equal 110. Any other value makes `illegal` high and `wr_en` low in the output cycle.
- R2: `sew_sel` encodes the element width as 0 = 8, 1 = 16, 2 = 32 bits. The value 3 is a 64-bit width, which cannot be widened. It raises `illegal` and suppresses the write.
- R3: The outputs are registered. `valid_out` is high exactly one cycle after `valid_in` was high. After reset, and after any cycle with `valid_in` low, `valid_out`, `wr_en`, `illegal`, `rd_idx` and `result` are all zero.
- R4: Bit 26 selects signedness. When it is 0, narrow operands are zero-extended to twice the element width. When it is 1, they are sign-extended.
- R5: Bit 27 selects subtraction, which computes the first (rs2-side) operand minus the second (rs1-side) operand. Both add and subtract wrap modulo 2^(2×width) with no saturation.
- R6: Bit 28 selects the wide form. In that form the low 2×width bits of `src_wide` are used unchanged, and only the second operand is extended.
- R7: When bit 25 (mask enable) is 0 and `mask_bit` is 0, `wr_en` is low and `result` is zero. When bit 25 is 1, `mask_bit` has no effect.
- R8: Bits of `result` above 2×width are zero. Input bits above the width being read (`src_wide`, `src_vec`, `src_scl`) have no effect.
- R9: For a valid instruction, `rd_idx` carries instruction bits [11:7] in the output cycle.
- R10: When bits [14:12] equal 110, the narrow operand is taken from the low bits of `src_scl` and `src_vec` is ignored. When they equal 010, it is taken from `src_vec`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Input operands and instruction are present |
| insn | input | 32 | Instruction word |
| sew_sel | input | 2 | Element width select (0=8, 1=16, 2=32, 3=unsupported) |
| src_wide | input | 64 | First operand, narrow or already wide (rs2 side) |
| src_vec | input | 32 | Narrow vector element (rs1 side) |
| src_scl | input | 64 | Scalar register value (rs1 side in scalar form) |
| mask_bit | input | 1 | Mask bit of this element |
| valid_out | output | 1 | Result cycle marker |
| wr_en | output | 1 | Destination element is to be written |
| illegal | output | 1 | Instruction or width not supported |
| rd_idx | output | 5 | Destination register index |
| result | output | 64 | Double-width result, zero above 2×width |

## Verification
The hardest case to reach is the wide form at the 32-bit width. There the whole 64-bit first operand must pass through untouched, while a sign-extended second operand carries across the full width. A narrow operand with only its top bit set shows up here only when the operand values are chosen on purpose. The stimulus therefore applies directed extreme values at every width: all-ones, only the top bit set, and zero minus one. It loads the unread upper input bits with garbage, and then runs a long random mix over all eight operations, both sources and all four widths, with mask and validity gaps placed between vectors.

// File: rtl/vwl_pkg.sv
package vwl_pkg;

    localparam int DW        = 64;   // result and scalar width
    localparam int NW        = 32;   // widest narrow element
    localparam int SEW_BASE  = 8;
    localparam int NUM_SEW   = 3;    // 8, 16, 32

    localparam logic [6:0] OPC_VEC   = 7'b1010111;
    localparam logic [2:0] SRC_VV    = 3'b010;
    localparam logic [2:0] SRC_VX    = 3'b110;
    localparam logic [2:0] GRP_WIDEN = 3'b110;

    typedef enum logic [1:0] {
        SEW_E8  = 2'd0,
        SEW_E16 = 2'd1,
        SEW_E32 = 2'd2,
        SEW_BAD = 2'd3
    } sew_e;

    typedef struct packed {
        logic       legal;
        logic       use_scl;
        logic       sgn;
        logic       sub;
        logic       wide;
        logic       vm;
        logic [4:0] rd;
    } dec_t;

    function automatic logic [DW-1:0] low_mask(input int bits);
        return {DW{1'b1}} >> (DW - bits);
    endfunction

endpackage

// File: rtl/vwl_decode.sv
module vwl_decode
    import vwl_pkg::*;
(
    input  logic [31:0] insn,
    input  logic [1:0]  sew_sel,
    output dec_t        dec
);
    logic [5:0] fn6;
    logic [2:0] src;
    logic       opc_ok;
    logic       src_ok;
    logic       grp_ok;
    logic       sew_ok;
    logic       dummy_unused;

    assign fn6    = insn[31:26];
    assign src    = insn[14:12];
    assign opc_ok = (insn[6:0] == OPC_VEC);
    assign src_ok = (src == SRC_VV) || (src == SRC_VX);
    assign grp_ok = (fn6[5:3] == GRP_WIDEN);
    assign sew_ok = (sew_e'(sew_sel) != SEW_BAD);
    assign dummy_unused = ^insn[24:15];

    always_comb begin
        dec.legal   = opc_ok && src_ok && grp_ok && sew_ok;
        dec.use_scl = (src == SRC_VX);
        dec.sgn     = fn6[0];
        dec.sub     = fn6[1];
        dec.wide    = fn6[2];
        dec.vm      = insn[25];
        dec.rd      = insn[11:7];
    end
endmodule

// File: rtl/vwl_ext.sv
module vwl_ext
    import vwl_pkg::*;
#(
    parameter int W_DATA = DW,
    parameter int N_SEW  = NUM_SEW,
    parameter int BASE   = SEW_BASE
)(
    input  logic [W_DATA-1:0] val,
    input  logic [1:0]        sew_sel,
    input  logic              sgn,
    output logic [W_DATA-1:0] ext
);
    logic [W_DATA-1:0] cand [N_SEW];

    for (genvar g = 0; g < N_SEW; g++) begin : g_width
        localparam int W = BASE << g;
        localparam logic [W_DATA-1:0] M = {W_DATA{1'b1}} >> (W_DATA - W);
        always_comb begin
            if (sgn && val[W-1]) cand[g] = val | ~M;
            else                 cand[g] = val & M;
        end
    end

    always_comb begin
        ext = '0;
        for (int i = 0; i < N_SEW; i++)
            if (int'(sew_sel) == i) ext = cand[i];
    end
endmodule

// File: rtl/vwl_alu.sv
module vwl_alu
    import vwl_pkg::*;
#(
    parameter int W_DATA = DW,
    parameter int N_SEW  = NUM_SEW,
    parameter int BASE   = SEW_BASE
)(
    input  logic [W_DATA-1:0] opa_raw,
    input  logic [W_DATA-1:0] opa_ext,
    input  logic [W_DATA-1:0] opb_ext,
    input  logic [1:0]        sew_sel,
    input  logic              wide,
    input  logic              sub,
    output logic [W_DATA-1:0] res
);
    logic [W_DATA-1:0] dmask [N_SEW];
    logic [W_DATA-1:0] m2;
    logic [W_DATA-1:0] a;
    logic [W_DATA-1:0] raw;

    for (genvar g = 0; g < N_SEW; g++) begin : g_mask
        localparam int W2 = 2 * (BASE << g);
        assign dmask[g] = {W_DATA{1'b1}} >> (W_DATA - W2);
    end

    always_comb begin
        m2 = '0;
        for (int i = 0; i < N_SEW; i++)
            if (int'(sew_sel) == i) m2 = dmask[i];
        a   = wide ? (opa_raw & m2) : opa_ext;
        raw = sub ? (a - opb_ext) : (a + opb_ext);
        res = raw & m2;
    end
endmodule

// File: rtl/vwl_lane.sv
module vwl_lane
    import vwl_pkg::*;
#(
    parameter int W_DATA = DW,
    parameter int W_VEC  = NW
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic [31:0]       insn,
    input  logic [1:0]        sew_sel,
    input  logic [W_DATA-1:0] src_wide,
    input  logic [W_VEC-1:0]  src_vec,
    input  logic [W_DATA-1:0] src_scl,
    input  logic              mask_bit,
    output logic              valid_out,
    output logic              wr_en,
    output logic              illegal,
    output logic [4:0]        rd_idx,
    output logic [W_DATA-1:0] result
);
    dec_t              dec;
    logic [W_DATA-1:0] narrow;
    logic [W_DATA-1:0] a_ext;
    logic [W_DATA-1:0] b_ext;
    logic [W_DATA-1:0] sum;
    logic              do_write;

    vwl_decode u_dec (.insn(insn), .sew_sel(sew_sel), .dec(dec));

    assign narrow = dec.use_scl ? src_scl : W_DATA'(src_vec);

    vwl_ext #(.W_DATA(W_DATA)) u_ext_a (
        .val(src_wide), .sew_sel(sew_sel), .sgn(dec.sgn), .ext(a_ext));

    vwl_ext #(.W_DATA(W_DATA)) u_ext_b (
        .val(narrow), .sew_sel(sew_sel), .sgn(dec.sgn), .ext(b_ext));

    vwl_alu #(.W_DATA(W_DATA)) u_alu (
        .opa_raw(src_wide), .opa_ext(a_ext), .opb_ext(b_ext),
        .sew_sel(sew_sel), .wide(dec.wide), .sub(dec.sub), .res(sum));

    assign do_write = valid_in && dec.legal && (dec.vm || mask_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_out <= 1'b0;
            wr_en     <= 1'b0;
            illegal   <= 1'b0;
            rd_idx    <= '0;
            result    <= '0;
        end else begin
            valid_out <= valid_in;
            wr_en     <= do_write;
            illegal   <= valid_in && !dec.legal;
            rd_idx    <= valid_in ? dec.rd : 5'd0;
            result    <= do_write ? sum : '0;
        end
    end
endmodule

// File: rtl/vwl_lane_chk.sv
module vwl_lane_chk (
    input logic        clk,
    input logic        rst,
    input logic        valid_in,
    input logic [31:0] insn,
    input logic [1:0]  sew_sel,
    input logic        mask_bit,
    input logic        valid_out,
    input logic        wr_en,
    input logic        illegal,
    input logic [63:0] result
);
    a_r3_latency: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> (!valid_out && !wr_en && !illegal));

    a_r2_no_wide_sew: assert property (@(posedge clk) disable iff (rst)
        (valid_in && sew_sel == 2'd3) |=> (illegal && !wr_en));

    a_r1_bad_opcode: assert property (@(posedge clk) disable iff (rst)
        (valid_in && insn[6:0] != 7'b1010111) |=> illegal);

    a_r7_masked_off: assert property (@(posedge clk) disable iff (rst)
        (valid_in && !insn[25] && !mask_bit) |=> !wr_en);

    a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (valid_in && sew_sel == 2'd0) |=> (result[63:16] == 48'd0));
endmodule

bind vwl_lane vwl_lane_chk u_chk (
    .clk(clk), .rst(rst), .valid_in(valid_in), .insn(insn),
    .sew_sel(sew_sel), .mask_bit(mask_bit), .valid_out(valid_out),
    .wr_en(wr_en), .illegal(illegal), .result(result));

// File: tb/vwl_lane_test.sv
module vwl_lane_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_in = 1'b0;
    logic [31:0] insn = '0;
    logic [1:0]  sew_sel = '0;
    logic [63:0] src_wide = '0;
    logic [31:0] src_vec = '0;
    logic [63:0] src_scl = '0;
    logic        mask_bit = 1'b0;
    logic        valid_out, wr_en, illegal;
    logic [4:0]  rd_idx;
    logic [63:0] result;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // expected outputs of the vector applied at the previous negedge
    logic        e_v, e_we, e_ill;
    logic [4:0]  e_rd;
    logic [63:0] e_res;
    string       e_tag;

    always #4 clk = ~clk;  // 125 MHz

    vwl_lane uut (
        .clk(clk), .rst(rst), .valid_in(valid_in), .insn(insn),
        .sew_sel(sew_sel), .src_wide(src_wide), .src_vec(src_vec),
        .src_scl(src_scl), .mask_bit(mask_bit), .valid_out(valid_out),
        .wr_en(wr_en), .illegal(illegal), .rd_idx(rd_idx), .result(result));

    function automatic logic [63:0] trunc(logic [63:0] v, int w);
        logic [63:0] m = (w >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        return v & m;
    endfunction

    function automatic logic [63:0] sx(logic [63:0] v, int w, bit sg);
        logic [63:0] t = trunc(v, w);
        if (sg && t[w-1]) t = t | ~trunc(64'hFFFF_FFFF_FFFF_FFFF, w);
        return t;
    endfunction

    function automatic logic [31:0] mk(logic [5:0] f6, logic vm, logic [2:0] f3, logic [4:0] rd);
        return {f6, vm, 5'd9, 5'd3, f3, rd, 7'b1010111};
    endfunction

    task automatic model(input logic v, input logic [31:0] i, input logic [1:0] s,
                         input logic [63:0] a, input logic [31:0] vb,
                         input logic [63:0] sb, input logic m);
        int w = 8 << s;
        logic legal;
        logic [63:0] nb, ea, eb, r;
        legal = (i[6:0] == 7'b1010111) && (i[14:12] == 3'b010 || i[14:12] == 3'b110)
                && (i[31:29] == 3'b110) && (s != 2'd3);
        nb = (i[14:12] == 3'b110) ? sb : {32'd0, vb};
        r  = '0;
        if (legal) begin
            ea = i[28] ? trunc(a, 2*w) : sx(a, w, i[26]);
            eb = sx(nb, w, i[26]);
            r  = trunc(i[27] ? ea - eb : ea + eb, 2*w);
        end
        e_v   = v;
        e_we  = v && legal && (i[25] || m);
        e_ill = v && !legal;
        e_rd  = v ? i[11:7] : 5'd0;
        e_res = e_we ? r : 64'd0;
    endtask

    task automatic compare();
        n_chk++;
        if (valid_out !== e_v || wr_en !== e_we || illegal !== e_ill ||
            rd_idx !== e_rd || result !== e_res) begin
            n_bad++;
            $display("FAIL %s: actual v=%b we=%b ill=%b rd=%0d res=%h expected v=%b we=%b ill=%b rd=%0d res=%h",
                     e_tag, valid_out, wr_en, illegal, rd_idx, result,
                     e_v, e_we, e_ill, e_rd, e_res);
        end
    endtask

    task automatic apply(input string tag, input logic v, input logic [31:0] i,
                         input logic [1:0] s, input logic [63:0] a,
                         input logic [31:0] vb, input logic [63:0] sb, input logic m);
        @(negedge clk);
        compare();
        valid_in = v; insn = i; sew_sel = s; src_wide = a;
        src_vec = vb; src_scl = sb; mask_bit = m;
        model(v, i, s, a, vb, sb, m);
        e_tag = tag;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        e_v = 0; e_we = 0; e_ill = 0; e_rd = 0; e_res = 0; e_tag = "R3 reset state";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R3: reset state checked at first compare
        apply("R3 idle", 0, mk(6'b110000, 1, 3'b010, 5'd1), 0, 64'h5, 32'h5, 0, 1);
        // R4 unsigned and signed add at 8 bits
        apply("R4 unsigned add", 1, mk(6'b110000, 1, 3'b010, 5'd2), 0, 64'hFF, 32'hFF, 0, 1);
        apply("R4 signed add", 1, mk(6'b110001, 1, 3'b010, 5'd3), 0, 64'hFF, 32'hFF, 0, 1);
        apply("R4 signed 16", 1, mk(6'b110001, 1, 3'b010, 5'd4), 1, 64'h8000, 32'h8000, 0, 1);
        // R5 subtraction and wrap
        apply("R5 unsigned sub wrap", 1, mk(6'b110010, 1, 3'b010, 5'd5), 0, 64'h0, 32'h1, 0, 1);
        apply("R5 signed sub 32", 1, mk(6'b110011, 1, 3'b010, 5'd6), 2, 64'h8000_0000, 32'h7FFF_FFFF, 0, 1);
        apply("R5 operand order", 1, mk(6'b110010, 1, 3'b010, 5'd7), 1, 64'h0010, 32'h0003, 0, 1);
        // R6 wide forms
        apply("R6 wide signed 16", 1, mk(6'b110101, 1, 3'b010, 5'd8), 1, 64'h8000_0001, 32'hFFFF, 0, 1);
        apply("R6 wide unsigned 32 wrap", 1, mk(6'b110100, 1, 3'b010, 5'd9), 2, 64'hFFFF_FFFF_FFFF_FFFF, 32'h1, 0, 1);
        apply("R6 wide signed sub 32", 1, mk(6'b110111, 1, 3'b010, 5'd10), 2, 64'h0, 32'h8000_0000, 0, 1);
        // R7 masking
        apply("R7 masked off", 1, mk(6'b110000, 0, 3'b010, 5'd11), 0, 64'h12, 32'h34, 0, 0);
        apply("R7 mask on", 1, mk(6'b110000, 0, 3'b010, 5'd12), 0, 64'h12, 32'h34, 0, 1);
        apply("R7 vm ignores mask", 1, mk(6'b110000, 1, 3'b010, 5'd13), 0, 64'h12, 32'h34, 0, 0);
        // R8 upper input garbage and zero upper result
        apply("R8 upper bits", 1, mk(6'b110001, 1, 3'b010, 5'd14), 0, 64'hDEAD_BEEF_CAFE_0081, 32'hABCD_EF7F, 0, 1);
        // R10 scalar source
        apply("R10 scalar src", 1, mk(6'b110001, 1, 3'b110, 5'd15), 1, 64'h0001, 32'h1234, 64'hFFFF_0000_0000_FFFE, 1);
        apply("R10 scalar wide", 1, mk(6'b110110, 1, 3'b110, 5'd16), 0, 64'h0100, 32'hFF, 64'h2, 1);
        // R1 decode rejects
        apply("R1 bad opcode", 1, mk(6'b110000, 1, 3'b010, 5'd17) ^ 32'h1, 0, 64'h1, 32'h1, 0, 1);
        apply("R1 bad source", 1, mk(6'b110000, 1, 3'b000, 5'd18), 0, 64'h1, 32'h1, 0, 1);
        apply("R1 bad op", 1, mk(6'b000000, 1, 3'b010, 5'd19), 0, 64'h1, 32'h1, 0, 1);
        // R2 unsupported width
        apply("R2 sew 64", 1, mk(6'b110000, 1, 3'b010, 5'd20), 3, 64'h1, 32'h1, 0, 1);
        // R9 destination field
        apply("R9 rd field", 1, mk(6'b110000, 1, 3'b010, 5'd31), 2, 64'h1, 32'h1, 0, 1);
        apply("R3 gap", 0, 32'h0, 0, 0, 0, 0, 0);
        // random mix: R4 R5 R6 R7 R8 R10
        for (int k = 0; k < 400; k++) begin
            logic [5:0] f6 = {3'b110, 3'($urandom)};
            logic [2:0] f3 = ($urandom % 8 == 0) ? 3'b001 : (($urandom % 2) ? 3'b110 : 3'b010);
            apply("R4 R5 R6 R7 R8 R10 random", ($urandom % 6) != 0,
                  mk(f6, 1'($urandom), f3, 5'($urandom)), 2'($urandom),
                  {$urandom, $urandom}, $urandom, {$urandom, $urandom}, 1'($urandom));
        end
        apply("R3 drain", 0, 32'h0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule